// File: doc/BRIEF.md
# Hiccup Overcurrent Retry Controller

This block sequences one high-side switch channel through an overcurrent event. When the digitized current-limit flag rises while the channel is conducting, the switch is left on, in current limit, for a programmed ON window. If the overload outlasts that window, the gate is forced off for an OFF window. The block then retries with another ON window, and it repeats this cycle for as long as the short remains. A load that draws inrush current for less than the ON window, such as a capacitor bank or a cold lamp filament, never causes a fault indication.

Both window lengths are counted in clock ticks. Each length has a flag that marks it as not programmed. If only the OFF length is missing, the OFF window is derived as 64 times the ON window. If both lengths are missing, the retry sequencing is bypassed and the channel conducts through the overload without reporting it. The lengths and the mode flags are sampled once, at the moment the channel leaves idle. A command drop or a supervisor kill returns the channel to idle.

Top module: `hiccup_retry_ctrl`

## Requirements
- R1: While conducting with retry enabled, a high `ovc` keeps `gate_en` high and raises `limiting` from the next cycle, for exactly L_on cycles. L_on is the captured ON length.
- R2: If `ovc` is high in the last cycle of an ON window, `gate_en` goes low for exactly L_off cycles. After that, if `ovc` is still high, a new ON window of L_on cycles starts, and the cycle repeats.
- R3: If `ovc` is low in the last cycle of an ON or OFF window, the channel returns to plain conduction: `gate_en`=1, `limiting`=0, `fault`=0.
- R4: `fault` is high in exactly the cycles of an OFF window. It is never high while `gate_en` is high, including during ON windows with `ovc` high.
- R5: When `off_unset`=1 and `on_unset`=0, L_off equals 64 × L_on.
- R6: When `on_unset`=1 and `off_unset`=1, a high `ovc` leaves `gate_en`=1, with `fault`=0 and `limiting`=0.
- R7: When `on_unset`=1 and `off_unset`=0, or when `on_len`=0, L_on is 1 cycle. When `off_len`=0, L_off is 1 cycle.
- R8: The lengths and unset flags are captured in the cycle the channel leaves idle. Later changes to them have no effect until the next exit from idle.
- R9: When `cmd_on` is low at a clock edge, the channel is idle after that edge: `gate_en`, `fault` and `limiting` are all 0. While idle, `ovc` has no effect.
- R10: When `kill` is high at a clock edge, the channel is idle after that edge, whatever the values of `cmd_on` and `ovc`.
- R11: While `rst_n` is low, `gate_en`, `fault` and `limiting` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kill | input | 1 | Synchronous force-off from the supervisor, highest priority |
| cmd_on | input | 1 | Channel on command |
| ovc | input | 1 | Digitized overcurrent / current-limit flag |
| on_len | input | LEN_W (16) | ON window length in ticks |
| off_len | input | LEN_W (16) | OFF window length in ticks |
| on_unset | input | 1 | ON length not programmed |
| off_unset | input | 1 | OFF length not programmed |
| gate_en | output | 1 | Switch gate enable |
| fault | output | 1 | Channel diagnostic, high during forced-off windows |
| limiting | output | 1 | Channel is inside an ON window in current limit |

## Verification
The bound checker checks these properties on every cycle:
- `fault` and `gate_en` are never high together.
- The window counter steps down by one per cycle.
- An overload still present at the end of an ON window always leads to a fault cycle.
- Bypass mode never produces a fault.
- A kill or a command drop idles the channel within one edge.

Only the bench scenarios can show the exact window lengths. These are the 64× derived OFF window, the one-tick ON window, the 15000-tick OFF window, and the fact that values captured at idle exit ignore later edits. The bench also shows that a short inrush clears without a fault pulse.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_CONDUCT = 2'd1,
      ST_ONWIN   = 2'd2,
      ST_OFFWIN  = 2'd3
   } hstate_e;
endpackage

// File: rtl/hiccup_len_sel.sv
// Captures the effective window lengths and the bypass mode at idle exit.
module hiccup_len_sel #(
   parameter int LEN_W      = 16,
   parameter int SCALE_LOG2 = 6,
   localparam int CNT_W     = LEN_W + SCALE_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [LEN_W-1:0] on_len,
   input  logic [LEN_W-1:0] off_len,
   input  logic             on_unset,
   input  logic             off_unset,
   output logic [CNT_W-1:0] on_ticks,
   output logic [CNT_W-1:0] off_ticks,
   output logic             bypass
);
   logic [LEN_W-1:0] on_eff;
   logic [LEN_W-1:0] off_prog;
   logic [CNT_W-1:0] off_dflt;
   logic [CNT_W-1:0] off_eff;

   // zero or unprogrammed lengths collapse to a single tick
   assign on_eff   = (on_unset || (on_len == '0)) ? LEN_W'(1) : on_len;
   assign off_prog = (off_len == '0) ? LEN_W'(1) : off_len;

   generate
      if (SCALE_LOG2 == 0) begin : g_unscaled
         assign off_dflt = CNT_W'(on_eff);
      end else begin : g_scaled
         assign off_dflt = CNT_W'(on_eff) << SCALE_LOG2;
      end
   endgenerate

   assign off_eff = off_unset ? off_dflt : CNT_W'(off_prog);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_ticks  <= CNT_W'(1);
         off_ticks <= CNT_W'(1);
         bypass    <= 1'b0;
      end else if (capture) begin
         on_ticks  <= CNT_W'(on_eff);
         off_ticks <= off_eff;
         bypass    <= on_unset && off_unset;
      end
   end
endmodule

// File: rtl/hiccup_timer.sv
// Down-counter: a load of N keeps expired low for N-1 run cycles.
module hiccup_timer #(
   parameter int CNT_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             expired,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val - CNT_W'(1);
      end else if (run && (cnt != '0)) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
   import hiccup_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    kill,
   input  logic    cmd_on,
   input  logic    ovc,
   input  logic    bypass,
   input  logic    expired,
   output hstate_e state,
   output logic    capture,
   output logic    load_on,
   output logic    load_off,
   output logic    run
);
   hstate_e nxt;

   always_comb begin
      nxt      = state;
      capture  = 1'b0;
      load_on  = 1'b0;
      load_off = 1'b0;
      if (kill || !cmd_on) begin
         nxt = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: begin
               nxt     = ST_CONDUCT;
               capture = 1'b1;
            end
            ST_CONDUCT: begin
               if (ovc && !bypass) begin
                  nxt     = ST_ONWIN;
                  load_on = 1'b1;
               end
            end
            ST_ONWIN: begin
               if (expired) begin
                  if (ovc) begin
                     nxt      = ST_OFFWIN;
                     load_off = 1'b1;
                  end else begin
                     nxt = ST_CONDUCT;
                  end
               end
            end
            ST_OFFWIN: begin
               if (expired) begin
                  if (ovc) begin
                     nxt     = ST_ONWIN;
                     load_on = 1'b1;
                  end else begin
                     nxt = ST_CONDUCT;
                  end
               end
            end
            default: nxt = ST_IDLE;
         endcase
      end
   end

   assign run = (state == ST_ONWIN) || (state == ST_OFFWIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/hiccup_retry_ctrl.sv
module hiccup_retry_ctrl
   import hiccup_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int SCALE_LOG2 = 6,
   localparam int CNT_W     = LEN_W + SCALE_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill,
   input  logic             cmd_on,
   input  logic             ovc,
   input  logic [LEN_W-1:0] on_len,
   input  logic [LEN_W-1:0] off_len,
   input  logic             on_unset,
   input  logic             off_unset,
   output logic             gate_en,
   output logic             fault,
   output logic             limiting
);
   generate
      if (LEN_W < 2 || LEN_W > 32) begin : g_bad_len
         $error("hiccup_retry_ctrl: LEN_W must lie in 2..32");
      end
      if (SCALE_LOG2 > 10) begin : g_bad_scale
         $error("hiccup_retry_ctrl: SCALE_LOG2 must not exceed 10");
      end
   endgenerate

   hstate_e          st;
   logic             capture, load_on, load_off, run, expired, bypass_q;
   logic [CNT_W-1:0] on_ticks, off_ticks, tmr_cnt, load_val;

   hiccup_len_sel #(.LEN_W(LEN_W), .SCALE_LOG2(SCALE_LOG2)) u_len (
      .clk(clk), .rst_n(rst_n), .capture(capture),
      .on_len(on_len), .off_len(off_len),
      .on_unset(on_unset), .off_unset(off_unset),
      .on_ticks(on_ticks), .off_ticks(off_ticks), .bypass(bypass_q)
   );

   hiccup_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .kill(kill), .cmd_on(cmd_on), .ovc(ovc),
      .bypass(bypass_q), .expired(expired), .state(st), .capture(capture),
      .load_on(load_on), .load_off(load_off), .run(run)
   );

   assign load_val = load_on ? on_ticks : off_ticks;

   hiccup_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(load_on || load_off),
      .load_val(load_val), .run(run), .expired(expired), .cnt(tmr_cnt)
   );

   assign gate_en  = (st == ST_CONDUCT) || (st == ST_ONWIN);
   assign limiting = (st == ST_ONWIN);
   assign fault    = (st == ST_OFFWIN);
endmodule

// File: rtl/hiccup_retry_chk.sv
module hiccup_retry_chk #(
   parameter int CNT_W = 22
) (
   input logic             clk,
   input logic             rst_n,
   input logic             kill,
   input logic             cmd_on,
   input logic             ovc,
   input logic             gate_en,
   input logic             fault,
   input logic             limiting,
   input logic             bypass,
   input logic [CNT_W-1:0] cnt
);
   logic in_win;
   assign in_win = limiting || fault;

   a_r4_fault_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !gate_en);

   a_r1_limit_start: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && !limiting && ovc && !bypass && cmd_on && !kill) |=> limiting);

   a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && cnt != '0 && cmd_on && !kill) |=> (cnt == $past(cnt) - 1'b1));

   a_r2_window_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (limiting && cnt == '0 && ovc && cmd_on && !kill) |=> fault);

   a_r6_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (!fault && !limiting));

   a_r9_cmd_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_on |=> (!gate_en && !fault && !limiting));

   a_r10_kill: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!gate_en && !fault && !limiting));
endmodule

bind hiccup_retry_ctrl hiccup_retry_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .kill(kill), .cmd_on(cmd_on), .ovc(ovc),
   .gate_en(gate_en), .fault(fault), .limiting(limiting),
   .bypass(bypass_q), .cnt(tmr_cnt)
);

// File: tb/sim_hiccup_retry_ctrl.sv
`timescale 1ns/1ps
module sim_hiccup_retry_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kill = 1'b0, cmd_on = 1'b0, ovc = 1'b0;
   logic [15:0] on_len = 16'd4, off_len = 16'd10;
   logic        on_unset = 1'b0, off_unset = 1'b0;
   logic        gate_en, fault, limiting;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   hiccup_retry_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .kill(kill), .cmd_on(cmd_on), .ovc(ovc),
      .on_len(on_len), .off_len(off_len), .on_unset(on_unset),
      .off_unset(off_unset), .gate_en(gate_en), .fault(fault),
      .limiting(limiting)
   );

   typedef struct packed {
      logic        k, c, o;
      logic [15:0] n;
      logic        g, f, l;
   } vec_t;

   // on_len=4, off_len=10; fields: kill, cmd, ovc, cycles, gate, fault, limiting
   localparam vec_t VT [21] = '{
      '{0,1,0, 1, 1,0,0},  // R3 conduct
      '{0,1,1, 1, 1,0,1},  // R1 enter ON window
      '{0,1,1, 3, 1,0,1},  // R1 R4 still in ON window
      '{0,1,1, 1, 0,1,0},  // R2 OFF window
      '{0,1,1, 9, 0,1,0},  // R2 R4 OFF lasts 10
      '{0,1,1, 1, 1,0,1},  // R2 retry
      '{0,1,0, 3, 1,0,1},  // R1 window runs out
      '{0,1,0, 1, 1,0,0},  // R3 resume from ON
      '{0,1,1, 2, 1,0,1},  // R4 inrush
      '{0,1,0, 2, 1,0,1},  // R4 inrush gone
      '{0,1,0, 1, 1,0,0},  // R4 no fault pulse
      '{0,1,1, 4, 1,0,1},  // R1
      '{0,1,1, 1, 0,1,0},  // R2
      '{0,1,0,10, 1,0,0},  // R3 resume from OFF
      '{0,1,1, 5, 0,1,0},  // R2
      '{0,0,1, 1, 0,0,0},  // R9 cmd drop
      '{0,0,1, 3, 0,0,0},  // R9 ovc ignored in idle
      '{0,1,0, 1, 1,0,0},  // R3
      '{1,1,0, 1, 0,0,0},  // R10 kill
      '{1,1,1, 3, 0,0,0},  // R10 kill holds
      '{0,1,0, 1, 1,0,0}   // R10 release
   };

   function automatic string tag_of(int i);
      case (i)
         1, 2, 6, 11:    return "R1";
         3, 4, 5, 12, 14: return "R2";
         0, 7, 13, 17:   return "R3";
         8, 9, 10:       return "R4";
         15, 16:         return "R9";
         default:        return "R10";
      endcase
   endfunction

   task automatic check3(string tag, logic eg, logic ef, logic el);
      n_chk++;
      if (gate_en !== eg || fault !== ef || limiting !== el) begin
         n_fail++;
         $display("FAIL %s: got g/f/l=%b%b%b expected %b%b%b", tag,
                  gate_en, fault, limiting, eg, ef, el);
      end
   endtask

   task automatic check_int(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // Channel must be conducting. Counts one ON and one OFF window.
   task automatic hiccup_once(string tag, int exp_on, int exp_off);
      int non = 0, noff = 0, bad = 0;
      ovc = 1'b1;
      @(negedge clk);
      while (limiting && non < 100000) begin
         non++;
         @(negedge clk);
      end
      while (!gate_en && noff < 100000) begin
         noff++;
         if (!fault) bad++;
         @(negedge clk);
      end
      check_int({tag, " ON window"}, non, exp_on);
      check_int({tag, " OFF window"}, noff, exp_off);
      check_int({tag, " R4 fault through OFF"}, bad, 0);
      ovc = 1'b0; cmd_on = 1'b0;
      @(negedge clk);
      check3({tag, " R9 back to idle"}, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check3("R11 reset", 0, 0, 0);
      cmd_on = 1'b1;
      @(negedge clk);
      check3("R11 held in reset", 0, 0, 0);
      cmd_on = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 21; i++) begin
         kill = VT[i].k; cmd_on = VT[i].c; ovc = VT[i].o;
         repeat (int'(VT[i].n)) @(posedge clk);
         @(negedge clk);
         check3($sformatf("%s vector %0d", tag_of(i), i), VT[i].g, VT[i].f, VT[i].l);
      end
      cmd_on = 1'b0; ovc = 1'b0; kill = 1'b0;
      @(negedge clk);

      // R5 with R8: default OFF is 64x ON; edits after idle exit ignored
      on_len = 16'd3; off_unset = 1'b1; cmd_on = 1'b1;
      @(negedge clk);
      on_len = 16'd9; off_unset = 1'b0; off_len = 16'd2;
      hiccup_once("R5 R8", 3, 192);

      // R7: ON unset alone gives a one-tick ON window
      on_unset = 1'b1; off_len = 16'd7; cmd_on = 1'b1;
      @(negedge clk);
      hiccup_once("R7 on_unset", 1, 7);

      // R7: zero lengths give one tick each
      on_unset = 1'b0; on_len = 16'd0; off_len = 16'd0; cmd_on = 1'b1;
      @(negedge clk);
      hiccup_once("R7 zero", 1, 1);

      // R2: long programmed windows
      on_len = 16'd64; off_len = 16'd15000; cmd_on = 1'b1;
      @(negedge clk);
      hiccup_once("R2 long", 64, 15000);

      // R6: bypass
      on_unset = 1'b1; off_unset = 1'b1; cmd_on = 1'b1;
      @(negedge clk);
      ovc = 1'b1;
      begin
         int bad = 0;
         for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (!gate_en || fault || limiting) bad++;
         end
         check_int("R6 bypass cycles with wrong outputs", bad, 0);
      end
      ovc = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule